// File: doc/BRIEF.md
# Zero-Run Output Guard

This block sits in front of a converter's output stage and decides, once per bit-clock cycle, whether that stage must be held at bipolar zero. It watches the serial-domain sample word and counts how many bit-clock cycles in a row the current word has been all zeros. When that run reaches a configurable threshold (65,536 cycles by default) and zero detection is enabled, the guard raises its force flag and replaces the outgoing data with zero.

Two overriding controls sit above the zero detector. An output-disable bit forces bipolar zero whatever the data is. The active-low reset forces it whatever every other control says. Reset wins over disable, and disable wins over zero detection. The force caused by a zero run ends in the same cycle that a valid non-zero sample appears, so that sample is passed through unchanged.

The "current word" is the word on `sample_in` in a cycle where `sample_vld` is high. In other cycles it is the last word accepted with `sample_vld` high. After reset the current word counts as zero.

Top module: `zero_run_guard`

## Requirements
- R1: While `rst_n` is low, `force_zero` is 1 and `sample_out` is 0, whatever the values of `out_disable`, `zero_det_en`, `sample_vld` and `sample_in`.
- R2: While `out_disable` is 1, `force_zero` is 1 and `sample_out` is 0, for any input data.
- R3: With `zero_det_en` at 1, `force_zero` becomes 1 in the cycle after the THRESH-th consecutive rising edge at which the current word was zero. Before that edge it stays 0 unless R1 or R2 applies.
- R4: With `zero_det_en` at 0, a zero run never raises `force_zero`. Zero words are passed through as zero.
- R5: In a cycle where `sample_vld` is 1 and `sample_in` is non-zero, with `rst_n` at 1 and `out_disable` at 0, `force_zero` is 0 and `sample_out` equals `sample_in`, even if a full zero run came before it.
- R6: A non-zero current word at any rising edge restarts the run, so a full run of THRESH new zero edges is needed before forcing again.
- R7: The run count saturates. A zero run of any length beyond THRESH keeps `force_zero` at 1 and never wraps back to the released state.
- R8: Whenever `force_zero` is 0, `sample_out` equals `sample_in`.
- R9: While `sample_vld` is 0, the last accepted word decides whether an edge counts as zero. A held non-zero word keeps the run cleared even when the `sample_in` bus reads zero.
- R10: The run is counted whether or not `zero_det_en` is set. Enabling detection after a completed run forces in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; the run is counted in its rising edges |
| rst_n | input | 1 | Active-low asynchronous reset and top-priority force |
| sample_in | input | W | Incoming sample word |
| sample_vld | input | 1 | High when `sample_in` carries a new word |
| zero_det_en | input | 1 | Enables forcing on a long zero run |
| out_disable | input | 1 | Forces bipolar zero when high |
| force_zero | output | 1 | High when the output stage must be held at bipolar zero |
| sample_out | output | W | `sample_in`, or zero while forced |

## Verification
The assertions assume that the controls and the data change only away from the rising bit-clock edge, and that `rst_n` is low at time zero so the checker's own run mirror starts from the same cleared state as the design. The checker keeps an independent saturating count of zero edges taken from the ports. From that count it checks the threshold in both directions, so the guard must not force early and must not miss the force. The bench runs a small configuration (8-bit words, threshold 8). It changes every input at the falling edge and samples one nanosecond later. It sweeps run lengths up to several times the threshold, every data value, and every combination of the two controls.

// File: rtl/zrg_pkg.sv
package zrg_pkg;
   // Reason the output stage is currently held at bipolar zero
   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_RESET   = 2'd1,
      CAUSE_DISABLE = 2'd2,
      CAUSE_ZERORUN = 2'd3
   } zrg_cause_e;

   function automatic int unsigned zrg_cnt_width(input int unsigned limit);
      return $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/zrg_word_mon.sv
// Tracks the current sample word and reports whether it is zero.
module zrg_word_mon #(
   parameter int unsigned W       = 24,
   parameter int unsigned GROUP_W = 8
) (
   input  logic         bit_clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample_in,
   input  logic         sample_vld,
   output logic         word_zero,
   output logic         live_nonzero
);
   localparam int unsigned NGRP  = (W + GROUP_W - 1) / GROUP_W;
   localparam int unsigned PAD_W = NGRP * GROUP_W;

   logic [PAD_W-1:0] padded;
   logic [NGRP-1:0]  grp_any;
   logic             in_nonzero;
   logic             held_zero_q;

   assign padded = PAD_W'(sample_in);

   // Grouped OR reduction keeps the depth to two balanced levels
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_any[g] = |padded[g*GROUP_W +: GROUP_W];
   end

   assign in_nonzero   = |grp_any;
   assign live_nonzero = sample_vld & in_nonzero;
   assign word_zero    = sample_vld ? ~in_nonzero : held_zero_q;

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         held_zero_q <= 1'b1;
      end else if (sample_vld) begin
         held_zero_q <= ~in_nonzero;
      end
   end
endmodule

// File: rtl/zrg_run_cnt.sv
// Saturating count of consecutive bit-clock edges with a zero word.
module zrg_run_cnt
   import zrg_pkg::*;
#(
   parameter int unsigned THRESH = 65536
) (
   input  logic bit_clk,
   input  logic rst_n,
   input  logic word_zero,
   output logic run_hit
);
   localparam int unsigned CNT_W = zrg_cnt_width(THRESH);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
   localparam bit POW2 = ((THRESH & (THRESH - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic             at_limit;

   if (POW2) begin : g_msb_hit
      // Count never passes the limit, so its top bit alone marks it
      assign at_limit = cnt_q[CNT_W-1];
   end else begin : g_cmp_hit
      assign at_limit = (cnt_q == LIMIT);
   end

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!word_zero) begin
         cnt_q <= '0;
      end else if (!at_limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign run_hit = at_limit;
endmodule

// File: rtl/zrg_force_arb.sv
// Priority between reset, output disable and zero-run forcing.
module zrg_force_arb
   import zrg_pkg::*;
#(
   parameter int unsigned W = 24
) (
   input  logic         rst_n,
   input  logic         out_disable,
   input  logic         zero_det_en,
   input  logic         run_hit,
   input  logic         live_nonzero,
   input  logic [W-1:0] sample_in,
   output logic         force_zero,
   output logic [W-1:0] sample_out
);
   zrg_cause_e cause;

   always_comb begin
      if (!rst_n) begin
         cause = CAUSE_RESET;
      end else if (out_disable) begin
         cause = CAUSE_DISABLE;
      end else if (zero_det_en && run_hit && !live_nonzero) begin
         cause = CAUSE_ZERORUN;
      end else begin
         cause = CAUSE_NONE;
      end
   end

   assign force_zero = (cause != CAUSE_NONE);

   for (genvar b = 0; b < W; b++) begin : g_mux
      assign sample_out[b] = sample_in[b] & ~force_zero;
   end
endmodule

// File: rtl/zero_run_guard.sv
module zero_run_guard #(
   parameter int unsigned W       = 24,
   parameter int unsigned THRESH  = 65536,
   parameter int unsigned GROUP_W = 8
) (
   input  logic         bit_clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample_in,
   input  logic         sample_vld,
   input  logic         zero_det_en,
   input  logic         out_disable,
   output logic         force_zero,
   output logic [W-1:0] sample_out
);
   if (W < 1) begin : g_bad_w
      $error("zero_run_guard: W must be at least 1");
   end
   if (THRESH < 2) begin : g_bad_thresh
      $error("zero_run_guard: THRESH must be at least 2");
   end
   if (GROUP_W < 1 || GROUP_W > W) begin : g_bad_grp
      $error("zero_run_guard: GROUP_W must lie in 1..W");
   end

   logic word_zero;
   logic live_nonzero;
   logic run_hit;

   zrg_word_mon #(.W(W), .GROUP_W(GROUP_W)) u_mon (
      .bit_clk      (bit_clk),
      .rst_n        (rst_n),
      .sample_in    (sample_in),
      .sample_vld   (sample_vld),
      .word_zero    (word_zero),
      .live_nonzero (live_nonzero)
   );

   zrg_run_cnt #(.THRESH(THRESH)) u_cnt (
      .bit_clk   (bit_clk),
      .rst_n     (rst_n),
      .word_zero (word_zero),
      .run_hit   (run_hit)
   );

   zrg_force_arb #(.W(W)) u_arb (
      .rst_n        (rst_n),
      .out_disable  (out_disable),
      .zero_det_en  (zero_det_en),
      .run_hit      (run_hit),
      .live_nonzero (live_nonzero),
      .sample_in    (sample_in),
      .force_zero   (force_zero),
      .sample_out   (sample_out)
   );
endmodule

// File: rtl/zero_run_guard_chk.sv
module zero_run_guard_chk #(
   parameter int unsigned W      = 24,
   parameter int unsigned THRESH = 65536
) (
   input logic         bit_clk,
   input logic         rst_n,
   input logic [W-1:0] sample_in,
   input logic         sample_vld,
   input logic         zero_det_en,
   input logic         out_disable,
   input logic         force_zero,
   input logic [W-1:0] sample_out
);
   localparam int unsigned RW = $clog2(THRESH + 1);

   // Port-level mirror of the zero run, used only to time the threshold checks
   logic [RW-1:0] zrun_q;
   logic          hz_q;
   logic          port_zero;
   logic          live_nz;

   assign live_nz   = sample_vld && (sample_in != '0);
   assign port_zero = sample_vld ? (sample_in == '0) : hz_q;

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         zrun_q <= '0;
         hz_q   <= 1'b1;
      end else begin
         if (sample_vld) hz_q <= (sample_in == '0);
         if (!port_zero) zrun_q <= '0;
         else if (zrun_q != RW'(THRESH)) zrun_q <= zrun_q + 1'b1;
      end
   end

   // R1
   reset_force_chk: assert property (@(posedge bit_clk)
      !rst_n |-> (force_zero && sample_out == '0));

   // R2
   disable_force_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      out_disable |-> force_zero);

   // R8
   forced_data_zero_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      force_zero |-> (sample_out == '0));

   // R8
   pass_through_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !force_zero |-> (sample_out == sample_in));

   // R5
   nonzero_release_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (!out_disable && live_nz) |-> !force_zero);

   // R4
   det_off_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (!zero_det_en && !out_disable) |-> !force_zero);

   // R3
   run_force_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (zero_det_en && !out_disable && !live_nz && zrun_q == RW'(THRESH)) |-> force_zero);

   // R3
   no_early_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (!out_disable && zrun_q != RW'(THRESH)) |-> !force_zero);
endmodule

bind zero_run_guard zero_run_guard_chk #(.W(W), .THRESH(THRESH)) u_chk (
   .bit_clk     (bit_clk),
   .rst_n       (rst_n),
   .sample_in   (sample_in),
   .sample_vld  (sample_vld),
   .zero_det_en (zero_det_en),
   .out_disable (out_disable),
   .force_zero  (force_zero),
   .sample_out  (sample_out)
);

// File: tb/zero_run_guard_tb.sv
`timescale 1ns/1ps
module zero_run_guard_tb;
   localparam int unsigned W = 8;
   localparam int unsigned T = 8;

   logic         bit_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] sample_in = '0;
   logic         sample_vld = 1'b0;
   logic         zero_det_en = 1'b0;
   logic         out_disable = 1'b0;
   logic         force_zero;
   logic [W-1:0] sample_out;

   int checks = 0;
   int errors = 0;

   // Bench model state: zero-edge run and last accepted word
   int m_run = 0;
   bit m_hz  = 1'b1;

   always #2 bit_clk = ~bit_clk;

   zero_run_guard #(.W(W), .THRESH(T), .GROUP_W(4)) u_dut (
      .bit_clk     (bit_clk),
      .rst_n       (rst_n),
      .sample_in   (sample_in),
      .sample_vld  (sample_vld),
      .zero_det_en (zero_det_en),
      .out_disable (out_disable),
      .force_zero  (force_zero),
      .sample_out  (sample_out)
   );

   task automatic chk(input string rq, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
      end
   endtask

   // One bit-clock cycle: drive at the falling edge, check, then advance the model
   task automatic cyc(input string rq, input logic v, input logic [W-1:0] d);
      bit ef;
      bit zn;
      @(negedge bit_clk);
      sample_vld = v;
      sample_in  = d;
      #1;
      ef = !rst_n || out_disable ||
           (zero_det_en && m_run == T && !(v && d != 0));
      chk(rq, {force_zero, sample_out}, {ef, ef ? {W{1'b0}} : d});
      @(posedge bit_clk);
      if (!rst_n) begin
         m_run = 0;
         m_hz  = 1'b1;
      end else begin
         zn = v ? (d == 0) : m_hz;
         if (v) m_hz = (d == 0);
         m_run = zn ? ((m_run == T) ? T : m_run + 1) : 0;
      end
   endtask

   task automatic set_ctl(input logic r, input logic zd, input logic od);
      @(negedge bit_clk);
      rst_n = r;
      zero_det_en = zd;
      out_disable = od;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset forces for every control combination and data value
      for (int c = 0; c < 4; c++) begin
         set_ctl(1'b0, c[0], c[1]);
         for (int d = 0; d < 256; d += 17) cyc("R1", 1'b1, W'(d));
      end

      // R3: threshold boundary, run of T-1 not forced, T forced
      set_ctl(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < T + 2; i++) cyc("R3", 1'b1, '0);
      // R7: long zero run stays forced
      for (int i = 0; i < 3 * T; i++) cyc("R7", 1'b0, '0);
      // R5: non-zero sample releases in the same cycle
      cyc("R5", 1'b1, 8'h5a);
      cyc("R5", 1'b1, 8'h01);

      // R6: a non-zero word restarts the run
      for (int i = 0; i < T - 1; i++) cyc("R6", 1'b1, '0);
      cyc("R6", 1'b1, 8'h80);
      for (int i = 0; i < T + 1; i++) cyc("R6", 1'b1, '0);

      // R9: held non-zero word keeps run clear while bus reads zero
      cyc("R9", 1'b1, 8'h10);
      for (int i = 0; i < 2 * T; i++) cyc("R9", 1'b0, '0);
      for (int i = 0; i < T + 1; i++) cyc("R9", 1'b1, '0);

      // R4/R8: detection off, every data value passes through
      set_ctl(1'b1, 1'b0, 1'b0);
      for (int d = 0; d < 256; d++) cyc("R8", 1'b1, W'(d));
      for (int i = 0; i < 2 * T; i++) cyc("R4", 1'b1, '0);

      // R10: run counted while disabled, enabling forces at once
      set_ctl(1'b1, 1'b1, 1'b0);
      cyc("R10", 1'b0, '0);

      // R2: output disable over every data value, both detect settings
      for (int c = 0; c < 2; c++) begin
         set_ctl(1'b1, c[0], 1'b1);
         for (int d = 0; d < 256; d += 5) cyc("R2", 1'b1, W'(d));
      end

      // Near-exhaustive sweep: run lengths around T, both control bits
      for (int c = 0; c < 4; c++) begin
         set_ctl(1'b1, c[0], c[1]);
         for (int len = 0; len <= T + 3; len++) begin
            cyc("R6", 1'b1, 8'h33);
            for (int i = 0; i < len; i++) cyc("R3", i[0], '0);
            cyc("R5", 1'b1, W'(len + 1));
         end
      end

      // R1: reset after a completed run clears it
      set_ctl(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < T + 1; i++) cyc("R3", 1'b1, '0);
      set_ctl(1'b0, 1'b1, 1'b0);
      cyc("R1", 1'b1, 8'h7e);
      set_ctl(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < T + 1; i++) cyc("R1", 1'b1, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule